// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Stage with Scoreboard

This block sits between a decode queue and the execution pipelines of a two-wide, statically scheduled, in-order core. Every cycle it looks at the two oldest decoded instructions. It decides whether to send none of them, only the older one, or both. It reads their register operands at that moment. On the next clock edge it presents the opcode, the destination and the operand values to execution, with one valid bit per issue slot.

A per-register scoreboard records pending writes as latency countdowns. When an instruction with a destination issues, its register is loaded with the number of cycles before a consumer can pick the result up through forwarding. The register counts as busy until the countdown reaches zero. A consumer operand that is read late, such as the data of a store, has a slack that lets it issue earlier. The same slack lets a producer and a dependent store share one issue cycle when forwarding can deliver the value in time. When it cannot, the pair is serialized.

Only one memory pipe exists, and either slot may feed it. An output flag names the slot that carries the load or store. A flush input discards the current candidates and clears the scoreboard in the same cycle.

Top module: `dual_issue_stage`

## Requirements
- R1: After reset, both issue-valid outputs are low, and an instruction whose operands are not written by any issued instruction issues in the first cycle it is presented.
- R2: Issue is strictly in program order. Slot 1 (younger) is accepted only in a cycle where slot 0 (older) is also accepted. If slot 0 stalls, nothing issues.
- R3: Two valid instructions with no mutual hazard issue together. On the following edge, each slot shows its opcode, its destination and the register file values read at its source addresses. Read port 0/1 serve slot 0 source A/B, and read port 2/3 serve slot 1 source A/B.
- R4: After an instruction of class C with a destination issues, a consumer of that register through a source with zero slack issues exactly LAT(C) cycles later. The default latencies are 1 for ALU, 3 for MUL and 2 for LOAD, and the classes are encoded ALU=0, MUL=1, LOAD=2, STORE=3.
- R5: If the younger instruction reads the older one's destination through a zero-slack source, only the older one issues that cycle.
- R6: A store (class 3) reads its data through source B with a slack of STORE_DATA_SLACK cycles (default 1). A store whose data comes from the older instruction of the pair co-issues with it when the producer's latency is not larger than that slack. A store whose address (source A) depends on the older instruction is serialized.
- R7: At most one load or store (class 2 or 3) issues per cycle. If both candidates are memory operations, only the older issues. The memory-valid output is set on the edge after a memory operation issues, and the memory-slot output is 0 or 1 for the slot that holds it.
- R8: A pair writing the same destination register is serialized. An instruction whose destination is still pending stalls until the pending countdown is below its own latency.
- R9: While flush is high, nothing is accepted, both issue-valid outputs are low on the next edge, and all pending scoreboard entries are cleared.
- R10: A candidate is never accepted while its valid input is low. Slot 1 valid alone issues nothing.
- R11: A load followed in the next cycle by a store that uses the load result as data issues back to back. A zero-slack consumer of a load stalls one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard candidates and clear scoreboard |
| inValid | input | 2 | Candidate valid, bit 0 = older |
| inReady | output | 2 | Candidate accepted (dequeue) this cycle |
| inOpc | input | 2 x OPC_W | Opcode per candidate |
| inCls | input | 2 x 2 | Class per candidate: 0 ALU, 1 MUL, 2 LOAD, 3 STORE |
| inDst | input | 2 x REG_AW | Destination register |
| inWr | input | 2 | Candidate writes its destination |
| inSrcA | input | 2 x REG_AW | Source A register |
| inUseA | input | 2 | Source A is read |
| inSrcB | input | 2 x REG_AW | Source B register |
| inUseB | input | 2 | Source B is read |
| rfRdAddr | output | 4 x REG_AW | Register file read addresses |
| rfRdData | input | 4 x XLEN | Register file read data (combinational) |
| issValid | output | 2 | Issued instruction valid per slot |
| issOpc | output | 2 x OPC_W | Issued opcode |
| issDst | output | 2 x REG_AW | Issued destination |
| issWr | output | 2 | Issued write flag |
| issOpA | output | 2 x XLEN | Issued operand A value |
| issOpB | output | 2 x XLEN | Issued operand B value |
| issMemValid | output | 1 | A memory operation issued |
| issMemSlot | output | 1 | Slot carrying the memory operation |

## Verification
The hardest cases to reach are the ones where a countdown and a pairing decision meet in the same cycle. Examples are a store whose data arrives from the partner in its own pair, and a consumer that arrives one cycle after a flush while a long multiply is still counting down. The stimulus first issues a producer of a known class alone. It then presents the dependent instruction at an exact cycle offset and compares the per-cycle accept pattern with the latency arithmetic. Pairs are then built with the dependence routed through the late or the early source, so that both sides of the forwarding rule are exercised.

// File: rtl/dis_pkg.sv
package dis_pkg;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_MUL   = 2'd1,
    CLS_LOAD  = 2'd2,
    CLS_STORE = 2'd3
  } opClass_e;

  // strobes from pairing control to the datapath side
  typedef struct packed {
    logic fire0;
    logic fire1;
    logic memValid;
    logic memSlot;
    logic flush;
  } issueStrobe_t;

  function automatic logic isMem(logic [1:0] c);
    return c[1];
  endfunction

  // cycles after issue before a consumer can take the value by forwarding
  function automatic int latOf(logic [1:0] c, int la, int lm, int ll);
    case (c)
      2'd1:    return lm;
      2'd2:    return ll;
      default: return la;
    endcase
  endfunction

  // how many cycles later than issue source B is consumed
  function automatic int slackOfB(logic [1:0] c, int s);
    return (c == 2'd3) ? s : 0;
  endfunction

endpackage

// File: rtl/dis_scoreboard.sv
module dis_scoreboard
  import dis_pkg::*;
#(
  parameter int NREG = 16,
  parameter int REG_AW = 4,
  parameter int LAT_ALU = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_LOAD = 2,
  parameter int STORE_DATA_SLACK = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  issueStrobe_t           strb,
  input  logic [1:0][1:0]        cls,
  input  logic [1:0][REG_AW-1:0] dst,
  input  logic [1:0]             wr,
  input  logic [1:0][REG_AW-1:0] srcA,
  input  logic [1:0][REG_AW-1:0] srcB,
  output logic [1:0]             okA,
  output logic [1:0]             okB,
  output logic [1:0]             okDst
);

  localparam int MAXLAT0 = (LAT_ALU > LAT_MUL) ? LAT_ALU : LAT_MUL;
  localparam int MAXLAT  = (MAXLAT0 > LAT_LOAD) ? MAXLAT0 : LAT_LOAD;
  localparam int CNT_W   = $clog2(MAXLAT + 1);

  logic [CNT_W-1:0] cnt [NREG];
  logic [1:0][CNT_W-1:0] loadVal;

  for (genvar k = 0; k < 2; k++) begin : g_slotLat
    assign loadVal[k] = CNT_W'(latOf(cls[k], LAT_ALU, LAT_MUL, LAT_LOAD) - 1);
  end

  for (genvar r = 0; r < NREG; r++) begin : g_entry
    logic hit0, hit1;
    assign hit0 = strb.fire0 && wr[0] && (dst[0] == REG_AW'(r));
    assign hit1 = strb.fire1 && wr[1] && (dst[1] == REG_AW'(r));
    always_ff @(posedge clk) begin
      if (!rstN || strb.flush) begin
        cnt[r] <= '0;
      end else if (hit1) begin
        cnt[r] <= loadVal[1];
      end else if (hit0) begin
        cnt[r] <= loadVal[0];
      end else if (cnt[r] != '0) begin
        cnt[r] <= cnt[r] - 1'b1;
      end
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_read
    assign okA[k]   = (cnt[srcA[k]] == '0);
    assign okB[k]   = int'(cnt[srcB[k]]) <= slackOfB(cls[k], STORE_DATA_SLACK);
    assign okDst[k] = int'(cnt[dst[k]]) < latOf(cls[k], LAT_ALU, LAT_MUL, LAT_LOAD);
  end

endmodule

// File: rtl/dis_pair_ctrl.sv
module dis_pair_ctrl
  import dis_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int LAT_ALU = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_LOAD = 2,
  parameter int STORE_DATA_SLACK = 1
) (
  input  logic                   flush,
  input  logic [1:0]             inValid,
  input  logic [1:0][1:0]        cls,
  input  logic [1:0][REG_AW-1:0] dst,
  input  logic [1:0]             wr,
  input  logic [1:0][REG_AW-1:0] srcA,
  input  logic [1:0]             useA,
  input  logic [1:0][REG_AW-1:0] srcB,
  input  logic [1:0]             useB,
  input  logic [1:0]             okA,
  input  logic [1:0]             okB,
  input  logic [1:0]             okDst,
  output issueStrobe_t           strb,
  output logic [1:0]             inReady
);

  logic [1:0] selfOk;
  logic       rawA, rawB, waw, memPair, pairOk;
  logic       can0, can1;

  for (genvar k = 0; k < 2; k++) begin : g_self
    assign selfOk[k] = inValid[k]
                     && (!useA[k] || okA[k])
                     && (!useB[k] || okB[k])
                     && (!wr[k] || okDst[k]);
  end

  always_comb begin
    rawA    = wr[0] && useA[1] && (srcA[1] == dst[0]);
    rawB    = wr[0] && useB[1] && (srcB[1] == dst[0])
              && (latOf(cls[0], LAT_ALU, LAT_MUL, LAT_LOAD)
                  > slackOfB(cls[1], STORE_DATA_SLACK));
    waw     = wr[0] && wr[1] && (dst[0] == dst[1]);
    memPair = isMem(cls[0]) && isMem(cls[1]);
    pairOk  = !rawA && !rawB && !waw && !memPair;
  end

  assign can0 = !flush && selfOk[0];
  assign can1 = can0 && selfOk[1] && pairOk;

  always_comb begin
    strb.fire0    = can0;
    strb.fire1    = can1;
    strb.flush    = flush;
    strb.memValid = (can0 && isMem(cls[0])) || (can1 && isMem(cls[1]));
    strb.memSlot  = !(can0 && isMem(cls[0]));
  end

  assign inReady = {can1, can0};

endmodule

// File: rtl/dis_issue_dp.sv
module dis_issue_dp
  import dis_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int REG_AW = 4,
  parameter int OPC_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  issueStrobe_t           strb,
  input  logic [1:0][OPC_W-1:0]  opc,
  input  logic [1:0][REG_AW-1:0] dst,
  input  logic [1:0]             wr,
  input  logic [1:0][REG_AW-1:0] srcA,
  input  logic [1:0][REG_AW-1:0] srcB,
  output logic [3:0][REG_AW-1:0] rfRdAddr,
  input  logic [3:0][XLEN-1:0]   rfRdData,
  output logic [1:0]             issValid,
  output logic [1:0][OPC_W-1:0]  issOpc,
  output logic [1:0][REG_AW-1:0] issDst,
  output logic [1:0]             issWr,
  output logic [1:0][XLEN-1:0]   issOpA,
  output logic [1:0][XLEN-1:0]   issOpB,
  output logic                   issMemValid,
  output logic                   issMemSlot
);

  logic [1:0] fire;
  assign fire = {strb.fire1, strb.fire0};

  for (genvar k = 0; k < 2; k++) begin : g_slot
    assign rfRdAddr[2*k]   = srcA[k];
    assign rfRdAddr[2*k+1] = srcB[k];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        issValid[k] <= 1'b0;
        issOpc[k]   <= '0;
        issDst[k]   <= '0;
        issWr[k]    <= 1'b0;
        issOpA[k]   <= '0;
        issOpB[k]   <= '0;
      end else begin
        issValid[k] <= fire[k];
        if (fire[k]) begin
          issOpc[k] <= opc[k];
          issDst[k] <= dst[k];
          issWr[k]  <= wr[k];
          issOpA[k] <= rfRdData[2*k];
          issOpB[k] <= rfRdData[2*k+1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issMemValid <= 1'b0;
      issMemSlot  <= 1'b0;
    end else begin
      issMemValid <= strb.memValid;
      issMemSlot  <= strb.memValid ? strb.memSlot : 1'b0;
    end
  end

endmodule

// File: rtl/dual_issue_stage.sv
module dual_issue_stage
  import dis_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int OPC_W = 8,
  parameter int LAT_ALU = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_LOAD = 2,
  parameter int STORE_DATA_SLACK = 1,
  localparam int REG_AW = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  logic [1:0]             inValid,
  output logic [1:0]             inReady,
  input  logic [1:0][OPC_W-1:0]  inOpc,
  input  logic [1:0][1:0]        inCls,
  input  logic [1:0][REG_AW-1:0] inDst,
  input  logic [1:0]             inWr,
  input  logic [1:0][REG_AW-1:0] inSrcA,
  input  logic [1:0]             inUseA,
  input  logic [1:0][REG_AW-1:0] inSrcB,
  input  logic [1:0]             inUseB,
  output logic [3:0][REG_AW-1:0] rfRdAddr,
  input  logic [3:0][XLEN-1:0]   rfRdData,
  output logic [1:0]             issValid,
  output logic [1:0][OPC_W-1:0]  issOpc,
  output logic [1:0][REG_AW-1:0] issDst,
  output logic [1:0]             issWr,
  output logic [1:0][XLEN-1:0]   issOpA,
  output logic [1:0][XLEN-1:0]   issOpB,
  output logic                   issMemValid,
  output logic                   issMemSlot
);

  issueStrobe_t strb;
  logic [1:0] okA, okB, okDst;

  dis_scoreboard #(
    .NREG(NREG), .REG_AW(REG_AW), .LAT_ALU(LAT_ALU), .LAT_MUL(LAT_MUL),
    .LAT_LOAD(LAT_LOAD), .STORE_DATA_SLACK(STORE_DATA_SLACK)
  ) u_sb (
    .clk(clk), .rstN(rstN), .strb(strb), .cls(inCls), .dst(inDst), .wr(inWr),
    .srcA(inSrcA), .srcB(inSrcB), .okA(okA), .okB(okB), .okDst(okDst)
  );

  dis_pair_ctrl #(
    .REG_AW(REG_AW), .LAT_ALU(LAT_ALU), .LAT_MUL(LAT_MUL),
    .LAT_LOAD(LAT_LOAD), .STORE_DATA_SLACK(STORE_DATA_SLACK)
  ) u_ctrl (
    .flush(flush), .inValid(inValid), .cls(inCls), .dst(inDst), .wr(inWr),
    .srcA(inSrcA), .useA(inUseA), .srcB(inSrcB), .useB(inUseB),
    .okA(okA), .okB(okB), .okDst(okDst), .strb(strb), .inReady(inReady)
  );

  dis_issue_dp #(
    .XLEN(XLEN), .REG_AW(REG_AW), .OPC_W(OPC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opc(inOpc), .dst(inDst), .wr(inWr),
    .srcA(inSrcA), .srcB(inSrcB), .rfRdAddr(rfRdAddr), .rfRdData(rfRdData),
    .issValid(issValid), .issOpc(issOpc), .issDst(issDst), .issWr(issWr),
    .issOpA(issOpA), .issOpB(issOpB), .issMemValid(issMemValid),
    .issMemSlot(issMemSlot)
  );

endmodule

// File: rtl/dis_checker.sv
module dis_checker #(
  parameter int REG_AW = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   flush,
  input logic [1:0]             inValid,
  input logic [1:0]             inReady,
  input logic [1:0][1:0]        inCls,
  input logic [1:0][REG_AW-1:0] inDst,
  input logic [1:0]             inWr,
  input logic [1:0][REG_AW-1:0] inSrcA,
  input logic [1:0]             inUseA,
  input logic [1:0]             issValid,
  input logic                   issMemValid,
  input logic                   issMemSlot
);

  AST_YOUNG_NEEDS_OLD: assert property (@(posedge clk) disable iff (!rstN)
    inReady[1] |-> inReady[0]); // R2

  AST_OUT_IN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    issValid[1] |-> issValid[0]); // R2

  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rstN)
    inReady[0] |=> issValid[0]); // R3

  AST_PAIR_RAW_SERIAL: assert property (@(posedge clk) disable iff (!rstN)
    (inWr[0] && inUseA[1] && inSrcA[1] == inDst[0]) |-> !inReady[1]); // R5

  AST_SINGLE_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (inReady == 2'b11) |-> !(inCls[0][1] && inCls[1][1])); // R7

  AST_MEM_SLOT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    issMemValid |-> issValid[issMemSlot]); // R7

  AST_NO_WAW_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (inReady == 2'b11 && inWr == 2'b11) |-> (inDst[0] != inDst[1])); // R8

  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (inReady == 2'b00)); // R9

  AST_FLUSH_QUIET_OUT: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (issValid == 2'b00)); // R9

  AST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (inReady & ~inValid) == 2'b00); // R10

endmodule

bind dual_issue_stage dis_checker #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .inReady(inReady),
  .inCls(inCls), .inDst(inDst), .inWr(inWr), .inSrcA(inSrcA), .inUseA(inUseA),
  .issValid(issValid), .issMemValid(issMemValid), .issMemSlot(issMemSlot)
);

// File: tb/dual_issue_stage_bench.sv
module dual_issue_stage_bench;

  localparam int XLEN = 32;
  localparam int REG_AW = 4;
  localparam int OPC_W = 8;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [1:0]        cls;
    logic [REG_AW-1:0] dst;
    logic              wr;
    logic [REG_AW-1:0] srcA;
    logic              useA;
    logic [REG_AW-1:0] srcB;
    logic              useB;
  } ins_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic [1:0] inValid = '0;
  logic [1:0] inReady;
  logic [1:0][OPC_W-1:0] inOpc = '0;
  logic [1:0][1:0] inCls = '0;
  logic [1:0][REG_AW-1:0] inDst = '0;
  logic [1:0] inWr = '0;
  logic [1:0][REG_AW-1:0] inSrcA = '0;
  logic [1:0] inUseA = '0;
  logic [1:0][REG_AW-1:0] inSrcB = '0;
  logic [1:0] inUseB = '0;
  logic [3:0][REG_AW-1:0] rfRdAddr;
  logic [3:0][XLEN-1:0] rfRdData;
  logic [1:0] issValid;
  logic [1:0][OPC_W-1:0] issOpc;
  logic [1:0][REG_AW-1:0] issDst;
  logic [1:0] issWr;
  logic [1:0][XLEN-1:0] issOpA;
  logic [1:0][XLEN-1:0] issOpB;
  logic issMemValid;
  logic issMemSlot;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [1:0] rdy;

  always #2 clk = ~clk;

  dual_issue_stage u_dual_issue_stage (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .inReady(inReady),
    .inOpc(inOpc), .inCls(inCls), .inDst(inDst), .inWr(inWr),
    .inSrcA(inSrcA), .inUseA(inUseA), .inSrcB(inSrcB), .inUseB(inUseB),
    .rfRdAddr(rfRdAddr), .rfRdData(rfRdData), .issValid(issValid),
    .issOpc(issOpc), .issDst(issDst), .issWr(issWr), .issOpA(issOpA),
    .issOpB(issOpB), .issMemValid(issMemValid), .issMemSlot(issMemSlot)
  );

  function automatic logic [XLEN-1:0] regVal(logic [REG_AW-1:0] a);
    return 32'hC0DE_0000 + 32'(a) * 32'd17;
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) rfRdData[i] = regVal(rfRdAddr[i]);
  end

  function automatic ins_t mk(logic [OPC_W-1:0] o, logic [1:0] c, logic w,
                              logic [REG_AW-1:0] d, logic ua, logic [REG_AW-1:0] a,
                              logic ub, logic [REG_AW-1:0] b);
    ins_t t;
    t.opc = o; t.cls = c; t.wr = w; t.dst = d;
    t.useA = ua; t.srcA = a; t.useB = ub; t.srcB = b;
    return t;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic putSlot(int k, ins_t t);
    inOpc[k] = t.opc; inCls[k] = t.cls; inDst[k] = t.dst; inWr[k] = t.wr;
    inSrcA[k] = t.srcA; inUseA[k] = t.useA; inSrcB[k] = t.srcB; inUseB[k] = t.useB;
  endtask

  // present candidates, capture accept pattern, advance one clock
  task automatic step(ins_t a, bit va, ins_t b, bit vb, bit fl);
    putSlot(0, a); putSlot(1, b);
    inValid = {vb, va};
    flush = fl;
    #1;
    rdy = inReady;
    @(posedge clk);
    #1;
    inValid = '0;
    flush = 1'b0;
  endtask

  ins_t nop;

  task automatic tReset();
    chk(issValid == 2'b00, "R1", "issValid after reset", 64'(issValid), 0);
    step(mk(8'h11, 2'd0, 1, 4'd1, 1, 4'd2, 1, 4'd3), 1, nop, 0, 0);
    chk(rdy == 2'b01, "R1", "fresh instr accepted", 64'(rdy), 1);
  endtask

  task automatic tIndepPair();
    step(mk(8'h21, 2'd0, 1, 4'd4, 1, 4'd2, 1, 4'd3),
         1, mk(8'h22, 2'd0, 1, 4'd5, 1, 4'd6, 1, 4'd8), 1, 0);
    chk(rdy == 2'b11, "R3", "independent pair ready", 64'(rdy), 3);
    chk(issValid == 2'b11, "R3", "both issued", 64'(issValid), 3);
    chk(issOpc[0] == 8'h21 && issOpc[1] == 8'h22, "R3", "opcodes",
        64'(issOpc), 64'(16'h2221));
    chk(issDst[1] == 4'd5, "R3", "slot1 dst", 64'(issDst[1]), 5);
    chk(issOpA[0] == regVal(4'd2), "R3", "slot0 opA", 64'(issOpA[0]), 64'(regVal(4'd2)));
    chk(issOpB[1] == regVal(4'd8), "R3", "slot1 opB", 64'(issOpB[1]), 64'(regVal(4'd8)));
  endtask

  task automatic tMulLatency();
    ins_t use7;
    use7 = mk(8'h31, 2'd0, 1, 4'd9, 1, 4'd7, 0, 4'd0);
    step(mk(8'h30, 2'd1, 1, 4'd7, 1, 4'd1, 1, 4'd2), 1, nop, 0, 0);
    step(use7, 1, nop, 0, 0);
    chk(rdy == 2'b00, "R4", "mul consumer +1 stalls", 64'(rdy), 0);
    step(use7, 1, nop, 0, 0);
    chk(rdy == 2'b00, "R4", "mul consumer +2 stalls", 64'(rdy), 0);
    step(use7, 1, nop, 0, 0);
    chk(rdy == 2'b01, "R4", "mul consumer +3 issues", 64'(rdy), 1);
  endtask

  task automatic tPairRaw();
    ins_t young;
    young = mk(8'h41, 2'd0, 1, 4'd11, 1, 4'd10, 1, 4'd3);
    step(mk(8'h40, 2'd0, 1, 4'd10, 1, 4'd1, 1, 4'd2), 1, young, 1, 0);
    chk(rdy == 2'b01, "R5", "dependent pair serialized", 64'(rdy), 1);
    chk(issValid == 2'b01, "R5", "only older issued", 64'(issValid), 1);
    step(young, 1, nop, 0, 0);
    chk(rdy == 2'b01, "R5", "younger issues next cycle", 64'(rdy), 1);
  endtask

  task automatic tStoreForward();
    step(mk(8'h50, 2'd0, 1, 4'd12, 1, 4'd1, 1, 4'd2),
         1, mk(8'h51, 2'd3, 0, 4'd0, 1, 4'd3, 1, 4'd12), 1, 0);
    chk(rdy == 2'b11, "R6", "alu + dependent store data paired", 64'(rdy), 3);
    chk(issMemValid && issMemSlot == 1'b1, "R6", "mem in slot1",
        64'({issMemValid, issMemSlot}), 3);
    step(mk(8'h52, 2'd0, 1, 4'd13, 1, 4'd1, 1, 4'd2),
         1, mk(8'h53, 2'd3, 0, 4'd0, 1, 4'd13, 1, 4'd4), 1, 0);
    chk(rdy == 2'b01, "R6", "store address dependence serialized", 64'(rdy), 1);
  endtask

  task automatic tMemPair();
    ins_t st;
    st = mk(8'h61, 2'd3, 0, 4'd0, 1, 4'd2, 1, 4'd3);
    step(mk(8'h60, 2'd2, 1, 4'd14, 1, 4'd1, 0, 4'd0), 1, st, 1, 0);
    chk(rdy == 2'b01, "R7", "two memory ops, older only", 64'(rdy), 1);
    chk(issMemValid && issMemSlot == 1'b0, "R7", "mem in slot0",
        64'({issMemValid, issMemSlot}), 2);
    step(st, 1, nop, 0, 0);
    chk(rdy == 2'b01, "R7", "store issues alone", 64'(rdy), 1);
    step(mk(8'h62, 2'd0, 1, 4'd6, 1, 4'd1, 1, 4'd2),
         1, mk(8'h63, 2'd2, 1, 4'd8, 1, 4'd3, 0, 4'd0), 1, 0);
    chk(rdy == 2'b11 && issMemValid && issMemSlot, "R7", "alu + load, mem slot1",
        64'({rdy, issMemValid, issMemSlot}), 15);
    step(nop, 0, nop, 0, 0);
    chk(!issMemValid, "R7", "mem valid drops", 64'(issMemValid), 0);
  endtask

  task automatic tLoadUse();
    ins_t useLd;
    step(mk(8'h70, 2'd2, 1, 4'd13, 1, 4'd1, 0, 4'd0), 1, nop, 0, 0);
    step(mk(8'h71, 2'd3, 0, 4'd0, 1, 4'd1, 1, 4'd13), 1, nop, 0, 0);
    chk(rdy == 2'b01, "R11", "store data back to back after load", 64'(rdy), 1);
    useLd = mk(8'h73, 2'd0, 1, 4'd2, 1, 4'd14, 0, 4'd0);
    step(mk(8'h72, 2'd2, 1, 4'd14, 1, 4'd1, 0, 4'd0), 1, nop, 0, 0);
    step(useLd, 1, nop, 0, 0);
    chk(rdy == 2'b00, "R11", "load use stalls one cycle", 64'(rdy), 0);
    step(useLd, 1, nop, 0, 0);
    chk(rdy == 2'b01, "R11", "load use then issues", 64'(rdy), 1);
  endtask

  task automatic tWaw();
    ins_t wr6;
    step(mk(8'h80, 2'd0, 1, 4'd5, 1, 4'd1, 0, 4'd0),
         1, mk(8'h81, 2'd0, 1, 4'd5, 1, 4'd2, 0, 4'd0), 1, 0);
    chk(rdy == 2'b01, "R8", "same-dst pair serialized", 64'(rdy), 1);
    wr6 = mk(8'h83, 2'd0, 1, 4'd6, 1, 4'd1, 0, 4'd0);
    step(mk(8'h82, 2'd1, 1, 4'd6, 1, 4'd1, 0, 4'd0), 1, nop, 0, 0);
    step(wr6, 1, nop, 0, 0);
    chk(rdy == 2'b00, "R8", "alu over pending mul dst stalls", 64'(rdy), 0);
    step(wr6, 1, nop, 0, 0);
    chk(rdy == 2'b00, "R8", "still pending", 64'(rdy), 0);
    step(wr6, 1, nop, 0, 0);
    chk(rdy == 2'b01, "R8", "issues once drained", 64'(rdy), 1);
  endtask

  task automatic tFlush();
    ins_t use15;
    use15 = mk(8'h91, 2'd0, 1, 4'd2, 1, 4'd15, 0, 4'd0);
    step(mk(8'h90, 2'd1, 1, 4'd15, 1, 4'd1, 0, 4'd0), 1, nop, 0, 0);
    step(use15, 1, mk(8'h92, 2'd0, 1, 4'd3, 1, 4'd1, 0, 4'd0), 1, 1);
    chk(rdy == 2'b00, "R9", "nothing accepted during flush", 64'(rdy), 0);
    chk(issValid == 2'b00, "R9", "no issue after flush", 64'(issValid), 0);
    step(use15, 1, nop, 0, 0);
    chk(rdy == 2'b01, "R9", "scoreboard cleared by flush", 64'(rdy), 1);
  endtask

  task automatic tOrderAndValid();
    step(mk(8'hA0, 2'd1, 1, 4'd3, 1, 4'd1, 0, 4'd0), 1, nop, 0, 0);
    step(mk(8'hA1, 2'd0, 1, 4'd4, 1, 4'd3, 0, 4'd0),
         1, mk(8'hA2, 2'd0, 1, 4'd5, 1, 4'd1, 0, 4'd0), 1, 0);
    chk(rdy == 2'b00, "R2", "older stalls, independent younger held", 64'(rdy), 0);
    chk(issValid == 2'b00, "R2", "no issue out of order", 64'(issValid), 0);
    step(nop, 0, mk(8'hA3, 2'd0, 1, 4'd7, 1, 4'd1, 0, 4'd0), 1, 0);
    chk(rdy == 2'b00, "R10", "slot1 alone not accepted", 64'(rdy), 0);
    chk(issValid == 2'b00, "R10", "slot1 alone no issue", 64'(issValid), 0);
  endtask

  initial begin
    nop = '0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    tReset();
    tIndepPair();
    tMulLatency();
    tPairRaw();
    tStoreForward();
    tMemPair();
    tLoadUse();
    repeat (4) step(nop, 0, nop, 0, 0);
    tWaw();
    repeat (4) step(nop, 0, nop, 0, 0);
    tFlush();
    repeat (4) step(nop, 0, nop, 0, 0);
    tOrderAndValid();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule